// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block produces the scan timing for a pixel display: horizontal and vertical sync, a data-enable strobe, and the x/y position of the current active pixel. A dot-clock enable is derived from the system clock by a programmable integer divider, and every raster step advances on that enable. Software loads the line and frame geometry through a simple register write/read port. The horizontal values are stored with a fixed 19-clock bias and the vertical values with a fixed 2-line bias, which cover the latency of a downstream pixel pipeline.

Outside the active area the colour output carries a programmable border colour. Inside it, the colour output passes the incoming pixel data. While scan-out is stopped, a separate "display off" colour is driven. A run bit selects between master mode and switch mode. Master mode drives the sync pins and scans. Switch mode stops the scan and releases the sync pins. A vertical-blank status flag is raised once per frame, cleared by writing one, and gated onto the interrupt line by an enable bit. Geometry writes made during a frame are held back until the next frame starts, so a frame is never torn.

Top module: `dtg_top`

## Requirements
- R1: After reset every register reads 0, scan-out is stopped, `sync_oe` is 0 and `rgb_out` is 0 (black for both the off colour and the border colour).
- R2: Register 1 bits 5:0 hold the dot-clock ratio minus one, and its upper bits read 0. While running, each raster position is held for exactly ratio clocks, for any ratio from 1 to 64.
- R3: With register 2 = HT and register 3 = HW, a line lasts HT+1 positions, and hsync is active for positions 0 through HW.
- R4: With register 4 = HS and register 5 = HE, `de` is high on line positions HS+19 through HE+18. While `de` is high, `pix_x` equals the position minus (HS+19). Otherwise `pix_x` is 0.
- R5: With register 6 = VT, register 7 = VS, register 8 = VE and register 9 = VP, a frame lasts VT+1 lines. Active lines run from VS+2 through VE+1, and vsync is active on lines VP+1 through VT. While `de` is high, `pix_y` equals the line minus (VS+2). Otherwise `pix_y` is 0.
- R6: Register 0 bit 1 makes hsync active-low, and register 0 bit 2 makes vsync active-low. Sync outputs rest at their inactive level.
- R7: Register 0 bit 0 = 1 is master mode. From the cycle after the write, `sync_oe` is 1 and the scan starts at line 0, position 0. Writing 0 selects switch mode: `sync_oe` is 0, `de` is 0 and both syncs sit at their inactive level.
- R8: `rgb_out` follows this priority: register 10 (off colour) while stopped; `pix_in` while `de` is high; register 11 (border colour) otherwise.
- R9: Geometry writes to registers 2 to 9 made during scan-out take effect only at the first position of the next frame.
- R10: Register 12 bit 0 (vblank status) becomes 1 on the first clock of the line after the last active line, once per frame.
- R11: Writing a value with bit 0 = 1 to register 12 clears the status. Writing a value with bit 0 = 0 leaves it unchanged.
- R12: `irq` equals the vblank status ANDed with register 13 bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pix_in | input | 24 | Pixel colour for the active area |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| sync_oe | output | 1 | High when the sync pins are actively driven |
| de | output | 1 | Data enable, high in the active area |
| pix_x | output | 12 | Active-area column |
| pix_y | output | 11 | Active-area row |
| rgb_out | output | 24 | Colour to the display |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
The embedded properties check the following on every cycle:
- divider ticks never come back to back when the ratio exceeds one;
- the position counter stays inside the shadowed line length;
- the shadow geometry holds still except at a frame boundary or while stopped;
- the counters sit at the origin after a stop;
- the status flag obeys its set and clear events.

Only the bench scenarios can show the full raster shape, by comparing every clock of whole frames against positions computed from the requirements. This covers the sync, data-enable and colour waveforms, the coordinates, the mid-frame geometry change landing on the next frame, both polarities, and ratios of 2, 3 and 64.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

  localparam int HCNT_W = 12;
  localparam int VCNT_W = 11;
  localparam int H_PIPE = 19;
  localparam int V_PIPE = 2;

  typedef logic [HCNT_W-1:0] hpos_t;
  typedef logic [VCNT_W-1:0] vpos_t;

  typedef struct packed {
    hpos_t htot;
    hpos_t hsw;
    hpos_t hds;
    hpos_t hde;
    vpos_t vtot;
    vpos_t vds;
    vpos_t vde;
    vpos_t vsp;
  } timing_t;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_DIV    = 4'd1,
    A_HTOT   = 4'd2,
    A_HSW    = 4'd3,
    A_HDS    = 4'd4,
    A_HDE    = 4'd5,
    A_VTOT   = 4'd6,
    A_VDS    = 4'd7,
    A_VDE    = 4'd8,
    A_VSP    = 4'd9,
    A_OFFCOL = 4'd10,
    A_BRDCOL = 4'd11,
    A_VSTAT  = 4'd12,
    A_VEN    = 4'd13
  } reg_addr_e;

  // First active column: the register is biased by the pixel pipeline depth.
  function automatic hpos_t h_first(timing_t t);
    return t.hds + hpos_t'(H_PIPE);
  endfunction

  function automatic hpos_t h_stop(timing_t t);
    return t.hde + hpos_t'(H_PIPE);
  endfunction

  function automatic vpos_t v_first(timing_t t);
    return t.vds + vpos_t'(V_PIPE);
  endfunction

  function automatic vpos_t v_stop(timing_t t);
    return t.vde + vpos_t'(V_PIPE);
  endfunction

  function automatic logic h_active(hpos_t hc, timing_t t);
    return (hc >= h_first(t)) && (hc < h_stop(t));
  endfunction

  function automatic logic v_active(vpos_t vc, timing_t t);
    return (vc >= v_first(t)) && (vc < v_stop(t));
  endfunction

  function automatic logic h_in_sync(hpos_t hc, timing_t t);
    return hc <= t.hsw;
  endfunction

  // Vsync begins on the line after the programmed position and ends at wrap.
  function automatic logic v_in_sync(vpos_t vc, timing_t t);
    return vc > t.vsp;
  endfunction

endpackage

// File: rtl/dtg_clkdiv.sv
`timescale 1ns/1ps
module dtg_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);

  logic [DIV_W-1:0] dcnt_q;
  logic             wrap;

  assign wrap = (dcnt_q >= div_m1);
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)      dcnt_q <= '0;
    else if (!run)   dcnt_q <= '0;
    else if (wrap)   dcnt_q <= '0;
    else             dcnt_q <= dcnt_q + 1'b1;
  end

  // R2: a ratio above one never gives two dot ticks in a row
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_m1 != '0 && $stable(div_m1)) |=> !tick);

endmodule

// File: rtl/dtg_regs.sv
`timescale 1ns/1ps
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 6,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               vbl_evt,
  output logic               run,
  output logic               hpol,
  output logic               vpol,
  output logic [DIV_W-1:0]   div_m1,
  output timing_t            timing,
  output logic [COLOR_W-1:0] off_rgb,
  output logic [COLOR_W-1:0] brd_rgb,
  output logic               irq
);

  logic [2:0]         ctrl_q;
  logic [DIV_W-1:0]   div_q;
  timing_t            tim_q;
  logic [COLOR_W-1:0] off_q;
  logic [COLOR_W-1:0] brd_q;
  logic               vbl_stat_q;
  logic               vbl_en_q;
  logic               vbl_clr;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:COLOR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      div_q    <= '0;
      tim_q    <= '0;
      off_q    <= '0;
      brd_q    <= '0;
      vbl_en_q <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        A_CTRL:   ctrl_q     <= wdata[2:0];
        A_DIV:    div_q      <= wdata[DIV_W-1:0];
        A_HTOT:   tim_q.htot <= wdata[HCNT_W-1:0];
        A_HSW:    tim_q.hsw  <= wdata[HCNT_W-1:0];
        A_HDS:    tim_q.hds  <= wdata[HCNT_W-1:0];
        A_HDE:    tim_q.hde  <= wdata[HCNT_W-1:0];
        A_VTOT:   tim_q.vtot <= wdata[VCNT_W-1:0];
        A_VDS:    tim_q.vds  <= wdata[VCNT_W-1:0];
        A_VDE:    tim_q.vde  <= wdata[VCNT_W-1:0];
        A_VSP:    tim_q.vsp  <= wdata[VCNT_W-1:0];
        A_OFFCOL: off_q      <= wdata[COLOR_W-1:0];
        A_BRDCOL: brd_q      <= wdata[COLOR_W-1:0];
        A_VEN:    vbl_en_q   <= wdata[0];
        default:  ;
      endcase
    end
  end

  // Write-one-to-clear status; a new frame event wins over a clear.
  assign vbl_clr = wr_en && (reg_addr_e'(addr) == A_VSTAT) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)       vbl_stat_q <= 1'b0;
    else if (vbl_evt) vbl_stat_q <= 1'b1;
    else if (vbl_clr) vbl_stat_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_CTRL:   rdata[2:0]         = ctrl_q;
      A_DIV:    rdata[DIV_W-1:0]   = div_q;
      A_HTOT:   rdata[HCNT_W-1:0]  = tim_q.htot;
      A_HSW:    rdata[HCNT_W-1:0]  = tim_q.hsw;
      A_HDS:    rdata[HCNT_W-1:0]  = tim_q.hds;
      A_HDE:    rdata[HCNT_W-1:0]  = tim_q.hde;
      A_VTOT:   rdata[VCNT_W-1:0]  = tim_q.vtot;
      A_VDS:    rdata[VCNT_W-1:0]  = tim_q.vds;
      A_VDE:    rdata[VCNT_W-1:0]  = tim_q.vde;
      A_VSP:    rdata[VCNT_W-1:0]  = tim_q.vsp;
      A_OFFCOL: rdata[COLOR_W-1:0] = off_q;
      A_BRDCOL: rdata[COLOR_W-1:0] = brd_q;
      A_VSTAT:  rdata[0]           = vbl_stat_q;
      A_VEN:    rdata[0]           = vbl_en_q;
      default:  rdata              = '0;
    endcase
  end

  assign run     = ctrl_q[0];
  assign hpol    = ctrl_q[1];
  assign vpol    = ctrl_q[2];
  assign div_m1  = div_q;
  assign timing  = tim_q;
  assign off_rgb = off_q;
  assign brd_rgb = brd_q;
  assign irq     = vbl_stat_q && vbl_en_q;

  // R10: a frame event always leaves the status set
  p_vbl_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_evt |=> vbl_stat_q);

  // R11: a clear without a competing event empties the status
  p_vbl_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_clr && !vbl_evt) |=> !vbl_stat_q);

  // R11: with neither event nor clear the status holds
  p_vbl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbl_clr && !vbl_evt) |=> $stable(vbl_stat_q));

endmodule

// File: rtl/dtg_raster.sv
`timescale 1ns/1ps
module dtg_raster
  import dtg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    tick,
  input  logic    hpol,
  input  logic    vpol,
  input  timing_t live,
  output logic    hsync,
  output logic    vsync,
  output logic    de,
  output hpos_t   pix_x,
  output vpos_t   pix_y,
  output logic    vbl_evt,
  output logic    frame_load
);

  hpos_t   hc_q;
  vpos_t   vc_q;
  timing_t sh_q;
  logic    h_last;
  logic    v_last;
  vpos_t   line_after;

  assign h_last     = (hc_q >= sh_q.htot);
  assign v_last     = (vc_q >= sh_q.vtot);
  assign frame_load = tick && h_last && v_last;

  // Unwrapped index of the line that starts after this one.
  assign line_after = v_last ? (sh_q.vtot + 1'b1) : (vc_q + 1'b1);
  assign vbl_evt    = tick && h_last && (line_after == v_stop(sh_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc_q <= '0;
      vc_q <= '0;
      sh_q <= '0;
    end else if (!run) begin
      hc_q <= '0;
      vc_q <= '0;
      sh_q <= live;
    end else if (tick) begin
      hc_q <= h_last ? '0 : hc_q + 1'b1;
      if (h_last) vc_q <= v_last ? '0 : vc_q + 1'b1;
      if (frame_load) sh_q <= live;
    end
  end

  assign de    = run && h_active(hc_q, sh_q) && v_active(vc_q, sh_q);
  assign hsync = (run && h_in_sync(hc_q, sh_q)) ^ hpol;
  assign vsync = (run && v_in_sync(vc_q, sh_q)) ^ vpol;
  assign pix_x = de ? hpos_t'(hc_q - h_first(sh_q)) : '0;
  assign pix_y = de ? vpos_t'(vc_q - v_first(sh_q)) : '0;

  // R3: the position counter never passes the shadowed line end
  p_hc_in_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hc_q <= sh_q.htot);

  // R9: the working geometry moves only at a frame boundary or while stopped
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_load) |=> $stable(sh_q));

  // R7: stopping returns the scan to the origin
  p_stop_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hc_q == '0 && vc_q == '0));

endmodule

// File: rtl/dtg_top.sv
`timescale 1ns/1ps
module dtg_top
  import dtg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 6,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [COLOR_W-1:0] pix_in,
  output logic               hsync,
  output logic               vsync,
  output logic               sync_oe,
  output logic               de,
  output logic [HCNT_W-1:0]  pix_x,
  output logic [VCNT_W-1:0]  pix_y,
  output logic [COLOR_W-1:0] rgb_out,
  output logic               irq
);

  logic               run;
  logic               hpol;
  logic               vpol;
  logic [DIV_W-1:0]   div_m1;
  timing_t            timing;
  logic [COLOR_W-1:0] off_rgb;
  logic [COLOR_W-1:0] brd_rgb;
  logic               tick;
  logic               vbl_evt;
  logic               frame_load;

  dtg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .COLOR_W(COLOR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .vbl_evt(vbl_evt), .run(run), .hpol(hpol), .vpol(vpol),
    .div_m1(div_m1), .timing(timing), .off_rgb(off_rgb), .brd_rgb(brd_rgb),
    .irq(irq)
  );

  dtg_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div_m1(div_m1), .tick(tick)
  );

  dtg_raster u_raster (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .hpol(hpol),
    .vpol(vpol), .live(timing), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .vbl_evt(vbl_evt), .frame_load(frame_load)
  );

  assign sync_oe = run;

  always_comb begin
    if (!run)    rgb_out = off_rgb;
    else if (de) rgb_out = pix_in;
    else         rgb_out = brd_rgb;
  end

  // R10: a vblank event can only come from a running scan
  p_evt_needs_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_evt |-> sync_oe);

endmodule

// File: tb/test_dtg_top.sv
`timescale 1ns/1ps
module test_dtg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [23:0] pix_in = 24'hABCDEF;
  logic [31:0] rdata;
  logic        hsync, vsync, sync_oe, de, irq;
  logic [11:0] pix_x;
  logic [10:0] pix_y;
  logic [23:0] rgb_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [23:0] OFFC = 24'h123456;
  localparam logic [23:0] BRDC = 24'h00FF00;

  typedef struct {
    logic        hs, vs, de, oe, irq;
    logic [11:0] x;
    logic [10:0] y;
    logic [23:0] rgb;
    int          s;
  } exp_t;

  exp_t q[$];

  dtg_top i_dtg_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pix_in(pix_in), .hsync(hsync), .vsync(vsync),
    .sync_oe(sync_oe), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .rgb_out(rgb_out), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // Expected raster from the requirement arithmetic: s clocks after start.
  task automatic push_window(input int ratio, input int htot, input int hsw,
                             input int hstart, input int hw0, input int hw1,
                             input int vtot, input int vstart, input int vact,
                             input int vsline, input bit hp, input bit vp,
                             input bit ien, input int n);
    for (int s = 0; s < n; s++) begin
      exp_t e;
      int px, hc, ln, vc, fr, hw;
      bit act;
      px = s / ratio;
      hc = px % htot;
      ln = px / htot;
      vc = ln % vtot;
      fr = ln / vtot;
      hw = (fr == 0) ? hw0 : hw1;
      act = (hc >= hstart) && (hc < hstart + hw) &&
            (vc >= vstart) && (vc < vstart + vact);
      e.hs  = (hc < hsw) ^ hp;
      e.vs  = (vc >= vsline) ^ vp;
      e.de  = act;
      e.oe  = 1'b1;
      e.irq = ien && (s >= (vstart + vact) * htot * ratio);
      e.x   = act ? 12'(hc - hstart) : 12'd0;
      e.y   = act ? 11'(vc - vstart) : 11'd0;
      e.rgb = act ? pix_in : BRDC;
      e.s   = s;
      q.push_back(e);
    end
  endtask

  task automatic start_run(input logic [2:0] ctrl, input int ratio,
                           input int hw0, input int hw1, input bit ien,
                           input int n);
    @(negedge clk);
    addr = 4'd0; wdata = {29'd0, ctrl}; wr_en = 1'b1;
    push_window(ratio, 30, 3, 24, hw0, hw1, 10, 3, 3, 8,
                ctrl[1], ctrl[2], ien, n);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Scoreboard monitor: one expected item per clock, sampled after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R3", "hsync", {31'd0, hsync}, {31'd0, e.hs});
        chk("R5", "vsync", {31'd0, vsync}, {31'd0, e.vs});
        chk("R4", "de", {31'd0, de}, {31'd0, e.de});
        chk("R4", "pix_x", {20'd0, pix_x}, {20'd0, e.x});
        chk("R5", "pix_y", {21'd0, pix_y}, {21'd0, e.y});
        chk("R8", "rgb_out", {8'd0, rgb_out}, {8'd0, e.rgb});
        chk("R7", "sync_oe", {31'd0, sync_oe}, {31'd0, e.oe});
        chk("R10", "irq", {31'd0, irq}, {31'd0, e.irq});
      end
    end
  end

  initial begin
    #1_200_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(4'd0, d);  chk("R1", "ctrl reads 0", d, 0);
    rd(4'd10, d); chk("R1", "off colour black", d, 0);
    rd(4'd11, d); chk("R1", "border black", d, 0);
    rd(4'd12, d); chk("R1", "status clear", d, 0);
    chk("R1", "sync_oe", {31'd0, sync_oe}, 0);
    chk("R1", "rgb_out", {8'd0, rgb_out}, 0);
    chk("R1", "de", {31'd0, de}, 0);

    // R2: divider field width
    wr(4'd1, 32'hFF);
    rd(4'd1, d); chk("R2", "div field masked", d, 32'h3F);

    // Geometry: 30 positions, hsync 3, active from 24 width 4; 10 lines,
    // active 3..5, vsync lines 8..9.
    wr(4'd1, 1);
    wr(4'd2, 29); wr(4'd3, 2); wr(4'd4, 5); wr(4'd5, 9);
    wr(4'd6, 9);  wr(4'd7, 1); wr(4'd8, 4); wr(4'd9, 7);
    wr(4'd10, {8'd0, OFFC}); wr(4'd11, {8'd0, BRDC});
    wr(4'd13, 1);
    @(negedge clk);
    #1 chk("R8", "off colour while stopped", {8'd0, rgb_out}, {8'd0, OFFC});

    // R6: polarity with the scan stopped
    wr(4'd0, 6);
    #1 chk("R6", "hsync idle high when active-low", {31'd0, hsync}, 1);
    chk("R6", "vsync idle high when active-low", {31'd0, vsync}, 1);
    chk("R7", "sync_oe off in switch mode", {31'd0, sync_oe}, 0);
    wr(4'd0, 0);

    // Run A: ratio 2, two frames; active width changed mid-frame (R9)
    start_run(3'b001, 2, 4, 5, 1'b1, 1200);
    repeat (100) @(negedge clk);
    wr(4'd5, 10);
    wait (q.size() == 0);

    // R10 / R11 / R12
    rd(4'd12, d); chk("R10", "status set after vblank", d, 1);
    wr(4'd12, 0);
    rd(4'd12, d); chk("R11", "write 0 keeps status", d, 1);
    wr(4'd12, 1);
    rd(4'd12, d); chk("R11", "write 1 clears status", d, 0);
    #1 chk("R12", "irq low after clear", {31'd0, irq}, 0);
    wait (irq == 1'b1);
    wr(4'd13, 0);
    #1 chk("R12", "irq masked by enable", {31'd0, irq}, 0);
    rd(4'd12, d); chk("R12", "status still set under mask", d, 1);

    // R7: stop
    wr(4'd0, 0);
    #1 chk("R7", "sync_oe after stop", {31'd0, sync_oe}, 0);
    chk("R7", "de after stop", {31'd0, de}, 0);
    chk("R7", "hsync inactive after stop", {31'd0, hsync}, 0);
    chk("R8", "off colour after stop", {8'd0, rgb_out}, {8'd0, OFFC});

    // Run B: ratio 3, both syncs active-low, irq masked
    wr(4'd12, 1);
    wr(4'd1, 2);
    start_run(3'b111, 3, 5, 5, 1'b0, 900);
    wait (q.size() == 0);
    wr(4'd0, 0);

    // Run C: ratio 64 boundary
    wr(4'd1, 63);
    start_run(3'b001, 64, 5, 5, 1'b0, 260);
    wait (q.size() == 0);
    wr(4'd0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule